// File: doc/BRIEF.md
# Transmit Mailbox Abort Controller

This block owns the status code of a single transmit message buffer and moves it through its life cycle. The CPU loads an identifier and payload words, then writes the DATA code to arm the buffer. An armed buffer asks for arbitration. When an external arbiter selects it and the shared transmit shadow buffer accepts the copy, the buffer counts as moved out. After that, the outcome reported by the protocol engine decides the final code. A successful frame leaves the buffer INACTIVE. A failed frame either sends the buffer back into arbitration or, when an abort is pending, ends it as ABORT. Both terminal outcomes raise an interrupt flag, which software clears by writing a one.

With abort-enable on, the CPU can cancel a transmission by writing the ABORT code. Whether the cancellation is honoured depends on timing. Before move-out it takes effect at once. After move-out it only waits for the frame outcome. In the same mode a raised flag locks the whole mailbox against CPU writes until software clears the flag. With abort-enable off, the CPU can instead inactivate the buffer directly. The frame in flight is then forgotten and produces no flag.

The move-out path is a valid/ready stream. `mo_valid` is offered only while the buffer is pending and selected. `mo_frame` is held steady while `mo_ready` is low, and the copy happens on the first cycle with both high. All other pins are plain control and status signals.

Top module: `txmb_abort_ctrl`

## Requirements
- R1: After reset, the code reads INACTIVE (4'h8), the interrupt flag is 0, and neither `arb_req` nor `mo_valid` is asserted.
- R2: From any idle code (INACTIVE or ABORT), a CPU write of DATA (4'hC) to word 0 sets the code to DATA and raises `arb_req` on the next cycle. While the code is DATA in arbitration, `arb_req` stays high.
- R3: `mo_valid` is high only while the buffer is pending (code DATA, no abort pending) and `arb_sel` is high. `mo_frame` holds word 1 (identifier) in bits [31:0], then the payload words upward. A cycle with `mo_valid` and `mo_ready` both high is the move-out: `arb_req` drops and the code stays DATA.
- R4: With `abort_en`=1, an ABORT (4'h9) write before move-out sets the code to ABORT and the flag on the next cycle, and removes the buffer from arbitration. An ABORT write in the same cycle as the move-out counts as after move-out.
- R5: With `abort_en`=1, an ABORT write after move-out raises `abort_pending` and leaves the code DATA. A later `tx_ok` gives INACTIVE plus the flag. A later `tx_fail` gives ABORT plus the flag.
- R6: `tx_fail` after move-out with no abort pending returns the buffer to arbitration with code DATA and does not set the flag.
- R7: `tx_ok` after move-out with no abort sets the code to INACTIVE and raises the flag.
- R8: With `abort_en`=1 and the flag set, every CPU write is dropped. This covers the code as well as the identifier and payload words.
- R9: `flag_clr` high for one cycle clears the flag. If the flag is set and cleared in the same cycle, the set wins.
- R10: An INACTIVE write is accepted only with `abort_en`=0. Once accepted, the buffer leaves arbitration, the code becomes INACTIVE, and the outcome of a frame already moved out sets no flag. With `abort_en`=1 the write is ignored.
- R11: With `abort_en`=0, an ABORT write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_en | input | 1 | Abort mode enable |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | Word select: 0 code, 1 identifier, 2..3 payload |
| cpu_wdata | input | 32 | CPU write data (code in bits [3:0]) |
| flag_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| mb_code | output | 4 | Current status code |
| abort_pending | output | 1 | Abort accepted after move-out, awaiting outcome |
| arb_req | output | 1 | Buffer is competing in arbitration |
| arb_sel | input | 1 | Arbiter selected this buffer |
| mo_valid | output | 1 | Move-out offer to the shadow buffer |
| mo_ready | input | 1 | Shadow buffer accepts the copy |
| mo_frame | output | 96 | Identifier and payload being moved out |
| tx_ok | input | 1 | Protocol engine: frame sent |
| tx_fail | input | 1 | Protocol engine: lost arbitration, bus error or error-state entry |

## Verification
A wrong state in the sequencer shows up one cycle after the stimulus that caused it. The symptoms are a wrong `mb_code`, an `arb_req` that is still high after move-out, a missing or spurious `irq_flag`, or a `mo_valid` offered by an aborted buffer. A storage fault in the payload words stays hidden until the next move-out. There it appears as a wrong `mo_frame`, and in particular a write that should have been blocked shows up in the copied frame. Every combination of abort mode, abort timing and frame outcome is swept, and each terminal code and flag state is compared one cycle after the event.

// File: rtl/txmb_pkg.sv
`timescale 1ns/1ps
package txmb_pkg;
  localparam logic [3:0] CODE_INACTIVE = 4'h8;
  localparam logic [3:0] CODE_ABORT    = 4'h9;
  localparam logic [3:0] CODE_DATA     = 4'hC;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PEND,
    ST_XMIT
  } mb_state_e;
endpackage

// File: rtl/txmb_words.sv
`timescale 1ns/1ps
module txmb_words #(
  parameter int WORD_W     = 32,
  parameter int DATA_WORDS = 2,
  parameter int AW         = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  output logic [(DATA_WORDS+1)*WORD_W-1:0] frame
);
  localparam int NPAY = DATA_WORDS + 1;

  for (genvar k = 0; k < NPAY; k++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && wr_addr == AW'(k + 1))
        word_q <= wr_data;
    end
    assign frame[k*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/txmb_flag.sv
`timescale 1ns/1ps
module txmb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_o <= 1'b0;
    else if (set_i)
      flag_o <= 1'b1;
    else if (clr_i)
      flag_o <= 1'b0;
  end
endmodule

// File: rtl/txmb_seq.sv
`timescale 1ns/1ps
module txmb_seq
  import txmb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_en,
  input  logic       code_we,
  input  logic [3:0] code_val,
  input  logic       arb_sel,
  input  logic       mo_ready,
  input  logic       tx_ok,
  input  logic       tx_fail,
  output logic [3:0] code_o,
  output logic       arb_req,
  output logic       mo_valid,
  output logic       abort_pending,
  output logic       flag_set
);
  mb_state_e  st_q, st_n;
  logic [3:0] code_q, code_n;
  logic       ap_q, ap_n;
  logic       new_abort, inact, arm, mo_fire;

  assign new_abort = code_we && (code_val == CODE_ABORT) && abort_en;
  assign inact     = code_we && (code_val == CODE_INACTIVE) && !abort_en;
  assign arm       = code_we && (code_val == CODE_DATA);
  assign mo_valid  = (st_q == ST_PEND) && arb_sel;
  assign mo_fire   = mo_valid && mo_ready;

  always_comb begin
    st_n     = st_q;
    code_n   = code_q;
    ap_n     = ap_q;
    flag_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (arm) begin
          st_n   = ST_PEND;
          code_n = CODE_DATA;
        end else if (inact) begin
          code_n = CODE_INACTIVE;
        end
      end
      ST_PEND: begin
        if (mo_fire) begin
          st_n = ST_XMIT;
          ap_n = new_abort;
        end
        if (inact) begin
          st_n   = ST_IDLE;
          code_n = CODE_INACTIVE;
          ap_n   = 1'b0;
        end else if (!mo_fire && new_abort) begin
          st_n     = ST_IDLE;
          code_n   = CODE_ABORT;
          flag_set = 1'b1;
        end
      end
      ST_XMIT: begin
        if (tx_ok) begin
          st_n     = ST_IDLE;
          code_n   = CODE_INACTIVE;
          ap_n     = 1'b0;
          flag_set = 1'b1;
        end else if (tx_fail) begin
          if (ap_q || new_abort) begin
            st_n     = ST_IDLE;
            code_n   = CODE_ABORT;
            ap_n     = 1'b0;
            flag_set = 1'b1;
          end else begin
            st_n = ST_PEND;
          end
        end else if (new_abort) begin
          ap_n = 1'b1;
        end else if (inact) begin
          st_n   = ST_IDLE;
          code_n = CODE_INACTIVE;
          ap_n   = 1'b0;
        end
      end
      default: begin
        st_n   = ST_IDLE;
        code_n = CODE_INACTIVE;
        ap_n   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      code_q <= CODE_INACTIVE;
      ap_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      code_q <= code_n;
      ap_q   <= ap_n;
    end
  end

  assign code_o        = code_q;
  assign arb_req       = (st_q == ST_PEND);
  assign abort_pending = ap_q;
endmodule

// File: rtl/txmb_abort_ctrl.sv
`timescale 1ns/1ps
module txmb_abort_ctrl #(
  parameter int WORD_W     = 32,
  parameter int DATA_WORDS = 2,
  localparam int NWORDS    = DATA_WORDS + 2,
  localparam int AW        = $clog2(NWORDS),
  localparam int FRAME_W   = (DATA_WORDS + 1) * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort_en,
  input  logic               cpu_we,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic               flag_clr,
  output logic               irq_flag,
  output logic [3:0]         mb_code,
  output logic               abort_pending,
  output logic               arb_req,
  input  logic               arb_sel,
  output logic               mo_valid,
  input  logic               mo_ready,
  output logic [FRAME_W-1:0] mo_frame,
  input  logic               tx_ok,
  input  logic               tx_fail
);
  logic wr_ok, code_we, flag_set;

  // a raised flag locks the whole mailbox while abort mode is on
  assign wr_ok   = cpu_we && !(abort_en && irq_flag);
  assign code_we = wr_ok && (cpu_addr == '0);

  txmb_words #(
    .WORD_W    (WORD_W),
    .DATA_WORDS(DATA_WORDS),
    .AW        (AW)
  ) i_words (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_ok),
    .wr_addr(cpu_addr),
    .wr_data(cpu_wdata),
    .frame  (mo_frame)
  );

  txmb_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_en     (abort_en),
    .code_we      (code_we),
    .code_val     (cpu_wdata[3:0]),
    .arb_sel      (arb_sel),
    .mo_ready     (mo_ready),
    .tx_ok        (tx_ok),
    .tx_fail      (tx_fail),
    .code_o       (mb_code),
    .arb_req      (arb_req),
    .mo_valid     (mo_valid),
    .abort_pending(abort_pending),
    .flag_set     (flag_set)
  );

  txmb_flag i_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .flag_o(irq_flag)
  );
endmodule

// File: rtl/txmb_abort_chk.sv
`timescale 1ns/1ps
module txmb_abort_chk
  import txmb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       abort_en,
  input logic       flag_clr,
  input logic       irq_flag,
  input logic [3:0] mb_code,
  input logic       abort_pending,
  input logic       arb_req,
  input logic       arb_sel,
  input logic       mo_valid
);
  AST_REQ_ONLY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req |-> mb_code == CODE_DATA); // R2

  AST_MOVEOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    mo_valid |-> arb_req && arb_sel && !abort_pending); // R3

  AST_ABORT_RAISES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_code == CODE_ABORT && $past(mb_code) != CODE_ABORT) |-> irq_flag); // R4

  AST_PENDING_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pending |-> mb_code == CODE_DATA && !arb_req); // R5

  AST_LOCKED_CODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_en && irq_flag && mb_code != CODE_DATA) |=> $stable(mb_code)); // R8

  AST_FLAG_FALLS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_flag) |-> $past(flag_clr)); // R9
endmodule

bind txmb_abort_ctrl txmb_abort_chk i_txmb_abort_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .abort_en     (abort_en),
  .flag_clr     (flag_clr),
  .irq_flag     (irq_flag),
  .mb_code      (mb_code),
  .abort_pending(abort_pending),
  .arb_req      (arb_req),
  .arb_sel      (arb_sel),
  .mo_valid     (mo_valid)
);

// File: tb/test_txmb_abort_ctrl.sv
`timescale 1ns/1ps
module test_txmb_abort_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        abort_en = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        flag_clr = 1'b0;
  logic        irq_flag;
  logic [3:0]  mb_code;
  logic        abort_pending;
  logic        arb_req;
  logic        arb_sel = 1'b0;
  logic        mo_valid;
  logic        mo_ready = 1'b0;
  logic [95:0] mo_frame;
  logic        tx_ok = 1'b0;
  logic        tx_fail = 1'b0;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  localparam logic [3:0] C_INACT = 4'h8;
  localparam logic [3:0] C_ABORT = 4'h9;
  localparam logic [3:0] C_DATA  = 4'hC;

  always #2.5 clk = ~clk;

  txmb_abort_ctrl i_txmb_abort_ctrl (
    .clk(clk), .rst_n(rst_n), .abort_en(abort_en), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .flag_clr(flag_clr),
    .irq_flag(irq_flag), .mb_code(mb_code), .abort_pending(abort_pending),
    .arb_req(arb_req), .arb_sel(arb_sel), .mo_valid(mo_valid),
    .mo_ready(mo_ready), .mo_frame(mo_frame), .tx_ok(tx_ok), .tx_fail(tx_fail)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [31:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    tick();
    cpu_we = 1'b0;
  endtask

  task automatic pulse_clr;
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic move_out(input logic [95:0] exp_frame);
    arb_sel = 1'b1; #1;
    chk("R3 mo_valid offered", 32'(mo_valid), 1);
    chk("R3 frame layout", 32'(mo_frame == exp_frame), 1);
    mo_ready = 1'b1;
    tick();
    arb_sel = 1'b0; mo_ready = 1'b0;
    chk("R3 arb_req after move-out", 32'(arb_req), 0);
    chk("R3 code after move-out", 32'(mb_code), 32'(C_DATA));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 code", 32'(mb_code), 32'(C_INACT));
    chk("R1 flag", 32'(irq_flag), 0);
    chk("R1 arb_req", 32'(arb_req), 0);
    chk("R1 mo_valid", 32'(mo_valid), 0);

    // sweep: abort mode x abort timing (0 none, 1 before, 2 after) x outcome (0 ok, 1 fail)
    for (int ae = 0; ae < 2; ae++) begin
      for (int tm = 0; tm < 3; tm++) begin
        for (int oc = 0; oc < 2; oc++) begin
          logic [31:0] id, d0, d1;
          logic [95:0] frm;
          bit aborted;
          do_reset();
          abort_en = ae[0];
          id = 32'h1000 + 32'(ae * 16 + tm * 4 + oc);
          d0 = id * 3 + 1;
          d1 = id * 7 + 5;
          frm = {d1, d0, id};
          cpu_wr(2'd1, id); cpu_wr(2'd2, d0); cpu_wr(2'd3, d1);
          cpu_wr(2'd0, 32'(C_DATA));
          chk("R2 armed code", 32'(mb_code), 32'(C_DATA));
          chk("R2 arb_req", 32'(arb_req), 1);

          if (tm == 1) begin
            cpu_wr(2'd0, 32'(C_ABORT));
            if (ae == 1) begin
              chk("R4 code ABORT", 32'(mb_code), 32'(C_ABORT));
              chk("R4 flag set", 32'(irq_flag), 1);
              chk("R4 left arbitration", 32'(arb_req), 0);
              arb_sel = 1'b1; #1;
              chk("R4 no move-out offer", 32'(mo_valid), 0);
              arb_sel = 1'b0;
              cpu_wr(2'd2, 32'hDEAD_BEEF);
              cpu_wr(2'd0, 32'(C_DATA));
              chk("R8 locked code write", 32'(mb_code), 32'(C_ABORT));
              pulse_clr();
              chk("R9 flag cleared", 32'(irq_flag), 0);
              cpu_wr(2'd0, 32'(C_DATA));
              chk("R8 rearm after clear", 32'(mb_code), 32'(C_DATA));
              move_out(frm);
              continue;
            end else begin
              chk("R11 abort ignored code", 32'(mb_code), 32'(C_DATA));
              chk("R11 abort ignored flag", 32'(irq_flag), 0);
            end
          end

          move_out(frm);
          aborted = (ae == 1) && (tm == 2);
          if (tm == 2) begin
            cpu_wr(2'd0, 32'(C_ABORT));
            chk("R5 abort_pending", 32'(abort_pending), 32'(aborted));
            chk("R5 code still DATA", 32'(mb_code), 32'(C_DATA));
          end

          if (oc == 0) begin
            tx_ok = 1'b1; tick(); tx_ok = 1'b0;
            chk("R7 code INACTIVE", 32'(mb_code), 32'(C_INACT));
            chk("R7 flag set", 32'(irq_flag), 1);
          end else begin
            tx_fail = 1'b1; tick(); tx_fail = 1'b0;
            if (aborted) begin
              chk("R5 code ABORT", 32'(mb_code), 32'(C_ABORT));
              chk("R5 flag set", 32'(irq_flag), 1);
            end else begin
              chk("R6 code DATA", 32'(mb_code), 32'(C_DATA));
              chk("R6 flag clear", 32'(irq_flag), 0);
              chk("R6 rejoined", 32'(arb_req), 1);
            end
          end
          if (irq_flag) begin
            pulse_clr();
            chk("R9 flag cleared", 32'(irq_flag), 0);
          end
        end
      end
    end

    // R10: inactivation in flight with abort mode off
    do_reset();
    abort_en = 1'b0;
    cpu_wr(2'd1, 32'h55); cpu_wr(2'd0, 32'(C_DATA));
    move_out({32'h0, 32'h0, 32'h55});
    cpu_wr(2'd0, 32'(C_INACT));
    chk("R10 inactivated code", 32'(mb_code), 32'(C_INACT));
    tx_ok = 1'b1; tick(); tx_ok = 1'b0;
    chk("R10 no flag for forgotten frame", 32'(irq_flag), 0);
    cpu_wr(2'd0, 32'(C_DATA));
    cpu_wr(2'd0, 32'(C_INACT));
    chk("R10 pending inactivated", 32'(arb_req), 0);

    // R10: inactivation refused with abort mode on
    do_reset();
    abort_en = 1'b1;
    cpu_wr(2'd0, 32'(C_DATA));
    cpu_wr(2'd0, 32'(C_INACT));
    chk("R10 ignored code", 32'(mb_code), 32'(C_DATA));
    chk("R10 ignored arb_req", 32'(arb_req), 1);

    // R9: set wins over a simultaneous clear
    cpu_wr(2'd0, 32'(C_ABORT));
    pulse_clr();
    cpu_wr(2'd0, 32'(C_DATA));
    flag_clr = 1'b1; cpu_we = 1'b1; cpu_addr = 2'd0; cpu_wdata = 32'(C_ABORT);
    tick();
    flag_clr = 1'b0; cpu_we = 1'b0;
    chk("R9 set beats clear", 32'(irq_flag), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule